// File: doc/BRIEF.md
# Serial Command Front-End for a Dual-Precision Sine/Cosine Engine

This block turns a plain asynchronous serial link into a command port for two sine/cosine compute engines of different precision. A host sends two-byte framed commands. A compute command carries a 32-bit phase word. The block trims that word to the phase width of the chosen engine, raises a request and waits for the engine's valid strobe. It then sends back the sine and the cosine, each widened to 32 bits with sign, as eight bytes on the transmit line.

Two more commands switch a stress mode on and off. While the mode is on, the clock-enable output given to the engines follows a pseudo-random pattern from an 8-bit LFSR, so each engine sees gaps in its enable. Four status outputs show which phase the block is in: idle, computing, stress mode and replying.

Top module: `trig_uart_frontend`

## Requirements
- R1: After synchronous reset, `st_ready_o` is 1, `st_calc_o`, `st_tx_o` and `st_mod_o` are 0, `tx_o` is 1 and `clk_en_o` is 1.
- R2: Both serial directions use 8N1 framing: one low start bit, eight data bits with the least significant bit first, and one high stop bit. Every bit lasts `BIT_CYCLES` clocks (868 gives 115200 baud from a 100 MHz clock). `tx_o` idles high whenever no reply is in progress.
- R3: A command is the sync byte 0x41 followed by an opcode byte. A byte other than 0x41 received while idle is discarded. An opcode outside 0x42..0x45 is discarded and the block returns to idle.
- R4: Opcode 0x42 is followed by four phase bytes, least significant first. It drives the low-precision port with the top `LO_PW` (20) bits of the phase. Opcode 0x43 does the same on the high-precision port with the top `HI_PW` (26) bits. At most one request is active at a time.
- R5: A compute command produces exactly eight reply bytes. The first four are the sine, sign-extended to 32 bits, least significant byte first. The last four are the cosine in the same format.
- R6: A request stays asserted until the selected port's valid input is sampled high. The block assumes no fixed latency.
- R7: Opcode 0x44 turns stress mode on and opcode 0x45 turns it off. Neither sends a reply. In stress mode `clk_en_o` follows bit 0 of a free-running 8-bit LFSR. Outside stress mode it is held at 1.
- R8: `st_ready_o` is 1 only while waiting for a sync byte. `st_calc_o` is 1 while a request is waiting for valid. `st_tx_o` is 1 while reply bytes are being sent. `st_mod_o` shows the stress mode. No two of ready, calc and tx are 1 at the same time.
- R9: Bytes that arrive while a computation or a reply is in progress are ignored. They do not change the stress mode and do not disturb the reply.
- R10: The receiver checks the start bit again half a bit period after the falling edge and drops a shorter low glitch. A byte whose stop bit is low is dropped, and the line must go high again before a new start bit is accepted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| rx_i | input | 1 | Serial receive line |
| tx_o | output | 1 | Serial transmit line |
| lo_req_o | output | 1 | Request to low-precision engine |
| lo_phase_o | output | LO_PW | Phase to low-precision engine |
| lo_valid_i | input | 1 | Low-precision result valid |
| lo_sin_i | input | LO_OW | Low-precision sine |
| lo_cos_i | input | LO_OW | Low-precision cosine |
| hi_req_o | output | 1 | Request to high-precision engine |
| hi_phase_o | output | HI_PW | Phase to high-precision engine |
| hi_valid_i | input | 1 | High-precision result valid |
| hi_sin_i | input | HI_OW | High-precision sine |
| hi_cos_i | input | HI_OW | High-precision cosine |
| clk_en_o | output | 1 | Clock enable toward both engines |
| st_ready_o | output | 1 | Idle, waiting for a sync byte |
| st_calc_o | output | 1 | Waiting for an engine result |
| st_mod_o | output | 1 | Stress mode on |
| st_tx_o | output | 1 | Reply in progress |

## Verification
The receiver can finish a byte in the same cycle that the transmitter is shifting out a reply. The parser then sees a valid received byte while it is in its reply state. The bench provokes this by sending a complete stress-on command (0x41 0x44) on the receive line partway through a reply. It judges the result by checking that all eight reply bytes still match the scoreboard, that the stress flag stays low and that the block returns to idle. A second overlap comes from the compute request and the clock-enable pattern: in stress mode the engine stub answers only when the enable is high, so the request must hold across the gaps and still produce the correct reply.

// File: rtl/trig_uart_frontend.sv
module trig_uart_frontend #(
  parameter int BIT_CYCLES = 868,
  parameter int LO_PW = 20,
  parameter int LO_OW = 18,
  parameter int HI_PW = 26,
  parameter int HI_OW = 24
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             rx_i,
  output logic             tx_o,
  output logic             lo_req_o,
  output logic [LO_PW-1:0] lo_phase_o,
  input  logic             lo_valid_i,
  input  logic [LO_OW-1:0] lo_sin_i,
  input  logic [LO_OW-1:0] lo_cos_i,
  output logic             hi_req_o,
  output logic [HI_PW-1:0] hi_phase_o,
  input  logic             hi_valid_i,
  input  logic [HI_OW-1:0] hi_sin_i,
  input  logic [HI_OW-1:0] hi_cos_i,
  output logic             clk_en_o,
  output logic             st_ready_o,
  output logic             st_calc_o,
  output logic             st_mod_o,
  output logic             st_tx_o
);
  localparam int CW = $clog2(BIT_CYCLES + 1);
  localparam logic [CW-1:0] FULL = CW'(BIT_CYCLES - 1);
  localparam logic [CW-1:0] HALF = CW'(BIT_CYCLES / 2 - 1);
  localparam logic [7:0] SYNC_B = 8'h41;
  localparam logic [7:0] OP_LO  = 8'h42;
  localparam logic [7:0] OP_HI  = 8'h43;
  localparam logic [7:0] OP_ON  = 8'h44;
  localparam logic [7:0] OP_OFF = 8'h45;

  // receiver
  logic [1:0] rx_sync;
  logic       rx_s;
  always_ff @(posedge clk)
    if (rst) rx_sync <= 2'b11;
    else     rx_sync <= {rx_sync[0], rx_i};
  assign rx_s = rx_sync[1];

  typedef enum logic [1:0] {RX_IDLE, RX_START, RX_DATA, RX_STOP} rx_st_t;
  rx_st_t        rx_st;
  logic [CW-1:0] rx_cnt;
  logic [2:0]    rx_bit;
  logic [7:0]    rx_sh;
  logic          rx_vld, rx_bad;

  always_ff @(posedge clk) begin
    if (rst) begin
      rx_st <= RX_IDLE; rx_cnt <= '0; rx_bit <= '0;
      rx_sh <= '0; rx_vld <= 1'b0; rx_bad <= 1'b0;
    end else begin
      rx_vld <= 1'b0;
      case (rx_st)
        RX_IDLE:
          if (!rx_s) begin rx_st <= RX_START; rx_cnt <= HALF; rx_bad <= 1'b0; end
        RX_START:
          if (rx_cnt != '0) rx_cnt <= rx_cnt - 1'b1;
          else if (!rx_s) begin rx_st <= RX_DATA; rx_cnt <= FULL; rx_bit <= '0; end
          else rx_st <= RX_IDLE;
        RX_DATA:
          if (rx_cnt != '0) rx_cnt <= rx_cnt - 1'b1;
          else begin
            rx_sh  <= {rx_s, rx_sh[7:1]};
            rx_cnt <= FULL;
            if (rx_bit == 3'd7) rx_st <= RX_STOP;
            else rx_bit <= rx_bit + 3'd1;
          end
        RX_STOP:
          if (rx_cnt != '0) rx_cnt <= rx_cnt - 1'b1;
          else if (rx_s) begin rx_st <= RX_IDLE; rx_vld <= !rx_bad; end
          else rx_bad <= 1'b1;
        default: rx_st <= RX_IDLE;
      endcase
    end
  end

  // command parser, request and reply serializer
  typedef enum logic [2:0] {S_IDLE, S_OP, S_PHASE, S_CALC, S_TX} st_t;
  st_t           st;
  logic          sel_hi, mod_on, got;
  logic [HI_PW-1:0] ph;
  logic [1:0]    ph_n;
  logic [55:0]   res;
  logic [9:0]    tx_sh;
  logic [CW-1:0] tx_cnt;
  logic [3:0]    tx_bit;
  logic [2:0]    tx_byte;
  logic [31:0]   sin_x, cos_x;
  logic [7:0]    lfsr;

  assign got   = sel_hi ? hi_valid_i : lo_valid_i;
  assign sin_x = sel_hi ? {{(32-HI_OW){hi_sin_i[HI_OW-1]}}, hi_sin_i}
                        : {{(32-LO_OW){lo_sin_i[LO_OW-1]}}, lo_sin_i};
  assign cos_x = sel_hi ? {{(32-HI_OW){hi_cos_i[HI_OW-1]}}, hi_cos_i}
                        : {{(32-LO_OW){lo_cos_i[LO_OW-1]}}, lo_cos_i};

  always_ff @(posedge clk) begin
    if (rst) begin
      st <= S_IDLE; sel_hi <= 1'b0; mod_on <= 1'b0; ph <= '0; ph_n <= '0;
      res <= '0; tx_sh <= '1; tx_cnt <= '0; tx_bit <= '0; tx_byte <= '0;
    end else begin
      case (st)
        S_IDLE:
          if (rx_vld && rx_sh == SYNC_B) st <= S_OP;
        S_OP:
          if (rx_vld) begin
            st <= S_IDLE;
            case (rx_sh)
              OP_LO:   begin sel_hi <= 1'b0; ph_n <= '0; st <= S_PHASE; end
              OP_HI:   begin sel_hi <= 1'b1; ph_n <= '0; st <= S_PHASE; end
              OP_ON:   mod_on <= 1'b1;
              OP_OFF:  mod_on <= 1'b0;
              default: ;
            endcase
          end
        S_PHASE:
          if (rx_vld) begin
            ph   <= {rx_sh, ph[HI_PW-1:8]};
            ph_n <= ph_n + 2'd1;
            if (ph_n == 2'd3) st <= S_CALC;
          end
        S_CALC:
          if (got) begin
            res     <= {cos_x, sin_x[31:8]};
            tx_sh   <= {1'b1, sin_x[7:0], 1'b0};
            tx_cnt  <= FULL;
            tx_bit  <= '0;
            tx_byte <= '0;
            st      <= S_TX;
          end
        S_TX:
          if (tx_cnt != '0) tx_cnt <= tx_cnt - 1'b1;
          else begin
            tx_cnt <= FULL;
            if (tx_bit == 4'd9) begin
              tx_bit <= '0;
              if (tx_byte == 3'd7) st <= S_IDLE;
              else begin
                tx_byte <= tx_byte + 3'd1;
                tx_sh   <= {1'b1, res[7:0], 1'b0};
                res     <= {8'h00, res[55:8]};
              end
            end else begin
              tx_sh  <= {1'b1, tx_sh[9:1]};
              tx_bit <= tx_bit + 4'd1;
            end
          end
        default: st <= S_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk)
    if (rst) lfsr <= 8'hA5;
    else     lfsr <= {lfsr[6:0], lfsr[7] ^ lfsr[5] ^ lfsr[4] ^ lfsr[3]};

  assign lo_phase_o = ph[HI_PW-1 -: LO_PW];
  assign hi_phase_o = ph;
  assign lo_req_o   = (st == S_CALC) && !sel_hi;
  assign hi_req_o   = (st == S_CALC) && sel_hi;
  assign clk_en_o   = mod_on ? lfsr[0] : 1'b1;
  assign tx_o       = (st == S_TX) ? tx_sh[0] : 1'b1;
  assign st_ready_o = (st == S_IDLE);
  assign st_calc_o  = (st == S_CALC);
  assign st_mod_o   = mod_on;
  assign st_tx_o    = (st == S_TX);

  assert_req_excl_R4: assert property (@(posedge clk) disable iff (rst)
    !(lo_req_o && hi_req_o));
  assert_lo_hold_R6: assert property (@(posedge clk) disable iff (rst)
    (lo_req_o && !lo_valid_i) |=> lo_req_o);
  assert_hi_hold_R6: assert property (@(posedge clk) disable iff (rst)
    (hi_req_o && !hi_valid_i) |=> hi_req_o);
  assert_en_high_R7: assert property (@(posedge clk) disable iff (rst)
    !st_mod_o |-> clk_en_o);
  assert_line_idle_R2: assert property (@(posedge clk) disable iff (rst)
    !st_tx_o |-> tx_o);
  assert_status_excl_R8: assert property (@(posedge clk) disable iff (rst)
    $onehot0({st_ready_o, st_calc_o, st_tx_o}));
  assert_tx_after_calc_R8: assert property (@(posedge clk) disable iff (rst)
    $rose(st_tx_o) |-> $past(st_calc_o));
  assert_mod_steady_R9: assert property (@(posedge clk) disable iff (rst)
    st_tx_o |=> $stable(st_mod_o));
endmodule

// File: tb/test_trig_uart_frontend.sv
module test_trig_uart_frontend;
  localparam int BIT = 16;
  logic clk = 1'b0, rst = 1'b1, rx = 1'b1;
  logic tx, lo_req, hi_req, lo_valid, hi_valid, clk_en;
  logic st_ready, st_calc, st_mod, st_tx;
  logic [19:0] lo_phase;
  logic [25:0] hi_phase;
  logic [17:0] lo_sin, lo_cos;
  logic [23:0] hi_sin, hi_cos;
  int checks = 0, errors = 0;
  logic [7:0] exp_q[$];
  bit saw_calc = 0;

  always #2 clk = ~clk;

  trig_uart_frontend #(.BIT_CYCLES(BIT)) i_trig_uart_frontend (
    .clk(clk), .rst(rst), .rx_i(rx), .tx_o(tx),
    .lo_req_o(lo_req), .lo_phase_o(lo_phase), .lo_valid_i(lo_valid),
    .lo_sin_i(lo_sin), .lo_cos_i(lo_cos),
    .hi_req_o(hi_req), .hi_phase_o(hi_phase), .hi_valid_i(hi_valid),
    .hi_sin_i(hi_sin), .hi_cos_i(hi_cos),
    .clk_en_o(clk_en), .st_ready_o(st_ready), .st_calc_o(st_calc),
    .st_mod_o(st_mod), .st_tx_o(st_tx));

  // engine stub: answers only while enabled
  assign lo_valid = lo_req & clk_en;
  assign hi_valid = hi_req & clk_en;
  assign lo_sin = lo_phase[19:2];
  assign lo_cos = ~lo_phase[19:2];
  assign hi_sin = hi_phase[25:2];
  assign hi_cos = ~hi_phase[25:2];

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic send_byte(input logic [7:0] b, input bit bad_stop = 0);
    rx = 1'b0; repeat (BIT) @(negedge clk);
    for (int i = 0; i < 8; i++) begin rx = b[i]; repeat (BIT) @(negedge clk); end
    rx = !bad_stop; repeat (BIT) @(negedge clk);
    rx = 1'b1; repeat (BIT) @(negedge clk);
  endtask

  task automatic calc(input bit hi, input logic [31:0] p);
    logic [31:0] s, c;
    if (hi) begin
      s = {{8{p[31]}}, p[31:8]};  c = {{8{~p[31]}}, ~p[31:8]};
    end else begin
      s = {{14{p[31]}}, p[31:14]}; c = {{14{~p[31]}}, ~p[31:14]};
    end
    for (int i = 0; i < 4; i++) exp_q.push_back(s[8*i +: 8]);
    for (int i = 0; i < 4; i++) exp_q.push_back(c[8*i +: 8]);
    send_byte(8'h41);
    send_byte(hi ? 8'h43 : 8'h42);
    for (int i = 0; i < 4; i++) send_byte(p[8*i +: 8]);
  endtask

  task automatic drain();
    int n = 0;
    while ((exp_q.size() != 0 || st_tx) && n < 6000) begin @(negedge clk); n++; end
    chk("R5 reply complete", {31'd0, exp_q.size() == 0}, 32'd1);
    repeat (4) @(negedge clk);
  endtask

  // monitor: decodes tx line, pops scoreboard
  initial begin
    logic [7:0] b;
    forever begin
      @(negedge clk);
      if (tx === 1'b0) begin
        chk("R8 tx flag during reply", {31'd0, st_tx}, 32'd1);
        repeat (BIT/2) @(negedge clk);
        chk("R2 start bit", {31'd0, tx}, 32'd0);
        for (int i = 0; i < 8; i++) begin repeat (BIT) @(negedge clk); b[i] = tx; end
        repeat (BIT) @(negedge clk);
        chk("R2 stop bit", {31'd0, tx}, 32'd1);
        if (exp_q.size() == 0) chk("R5 unexpected byte", {24'd0, b}, 32'hFFFF_FFFF);
        else chk("R5 reply byte", {24'd0, b}, {24'd0, exp_q.pop_front()});
      end
    end
  end

  always @(negedge clk) if (st_calc) saw_calc = 1;

  initial begin
    repeat (150000) @(posedge clk);
    checks++; errors++;
    $display("FAIL watchdog expired");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    int lo_n, hi_n;
    repeat (5) @(negedge clk);
    rst = 1'b0;
    repeat (2) @(negedge clk);
    chk("R1 ready", {31'd0, st_ready}, 32'd1);
    chk("R1 calc", {31'd0, st_calc}, 32'd0);
    chk("R1 tx flag", {31'd0, st_tx}, 32'd0);
    chk("R1 mod", {31'd0, st_mod}, 32'd0);
    chk("R1 line", {31'd0, tx}, 32'd1);
    chk("R1 clk_en", {31'd0, clk_en}, 32'd1);

    calc(0, 32'h1234_5678); drain();
    chk("R8 calc flag seen", {31'd0, saw_calc}, 32'd1);
    calc(1, 32'hFEDC_BA98); drain();
    calc(0, 32'h8000_0000); drain();
    calc(1, 32'h7FFF_FFFF); drain();
    chk("R4 phase to lo port", {12'd0, lo_phase}, 32'h7_FFFF);
    chk("R8 ready after reply", {31'd0, st_ready}, 32'd1);

    send_byte(8'h55);
    chk("R3 non-sync byte stays idle", {31'd0, st_ready}, 32'd1);
    send_byte(8'h41);
    chk("R8 ready low after sync", {31'd0, st_ready}, 32'd0);
    send_byte(8'h50);
    chk("R3 bad opcode back to idle", {31'd0, st_ready}, 32'd1);
    calc(0, 32'h0000_F00D); drain();

    send_byte(8'h41); send_byte(8'h44);
    chk("R7 mod on", {31'd0, st_mod}, 32'd1);
    chk("R7 no reply ready", {31'd0, st_ready}, 32'd1);
    lo_n = 0; hi_n = 0;
    for (int i = 0; i < 200; i++) begin
      @(negedge clk); if (clk_en) hi_n++; else lo_n++;
    end
    chk("R7 pattern has lows", {31'd0, lo_n > 0}, 32'd1);
    chk("R7 pattern has highs", {31'd0, hi_n > 0}, 32'd1);
    saw_calc = 0;
    calc(1, 32'hA5A5_5A5A); drain();
    calc(0, 32'hC3C3_3C3C); drain();
    chk("R6 result under gated enable", {31'd0, saw_calc}, 32'd1);
    send_byte(8'h41); send_byte(8'h45);
    chk("R7 mod off", {31'd0, st_mod}, 32'd0);
    lo_n = 0;
    for (int i = 0; i < 200; i++) begin @(negedge clk); if (!clk_en) lo_n++; end
    chk("R7 clk_en held high", lo_n, 32'd0);

    calc(0, 32'h0102_0304);
    wait (st_tx == 1'b1);
    repeat (BIT*10) @(negedge clk);
    send_byte(8'h41); send_byte(8'h44);
    chk("R9 still replying", {31'd0, st_tx}, 32'd1);
    drain();
    chk("R9 ignored command during reply", {31'd0, st_mod}, 32'd0);
    chk("R9 idle after reply", {31'd0, st_ready}, 32'd1);

    rx = 1'b0; repeat (3) @(negedge clk); rx = 1'b1;
    repeat (2*BIT) @(negedge clk);
    send_byte(8'h41); send_byte(8'h44);
    chk("R10 glitch ignored", {31'd0, st_mod}, 32'd1);
    send_byte(8'h41);
    send_byte(8'h45, 1);
    chk("R10 framing error dropped mod", {31'd0, st_mod}, 32'd1);
    chk("R10 framing error still in opcode wait", {31'd0, st_ready}, 32'd0);
    send_byte(8'h45);
    chk("R10 next good byte accepted", {31'd0, st_mod}, 32'd0);
    chk("R3 back to idle", {31'd0, st_ready}, 32'd1);
    repeat (50) @(negedge clk);
    chk("R5 no stray bytes", exp_q.size(), 32'd0);

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule